// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block turns the module clock into the serial clock of an SPI master. The frame engine raises `run` for the length of a frame. While `run` is high the block toggles `sck` once every half period. The half period, counted in module clock cycles, is the product of a prescaler factor and a scaler factor, divided by two. Each toggle comes with a one-cycle strobe that tells the frame engine whether to launch the next data bit or capture the incoming one.

A frame starts on the first clock edge at which `run` is high and the block is idle. On that edge the block latches the prescaler code, the scaler code, the polarity and the phase, and clears its counters. Changes to these inputs while the frame runs have no effect until the next start. Lowering `run` stops the block on the next edge and returns `sck` to its idle level.

The interface is plain control: there is no data stream, so there is no valid/ready handshake. The strobes are single-cycle pulses with no back-pressure. The frame engine must act on each strobe in the cycle it appears.

Top module: `spi_sck_div`

## Requirements
- R1: While the block is not running, `sck` equals the `cpol` input. This includes reset, and `cpol` = 1 gives an idle-high clock.
- R2: Let S be the start edge. `sck` keeps the latched `cpol` level until edge S+H, where H is the half period. The first toggle is at S+H, and every later toggle follows H edges after the previous one.
- R3: Prescaler code 0, 1, 2 and 3 selects factor 2, 3, 5 and 7.
- R4: Scaler codes 0 to 3 select 2, 4, 6 and 8. Code k from 4 to 15 selects 2^k. H is prescaler factor × scaler factor / 2, so code pair (3,15) gives the largest H, 114688.
- R5: With the latched `cpha` = 0, `sample_stb` pulses after each odd-numbered toggle (leading edges) and `shift_stb` after each even-numbered toggle (trailing edges).
- R6: With the latched `cpha` = 1, `shift_stb` pulses on leading edges and `sample_stb` on trailing edges.
- R7: A strobe is high for exactly the one cycle after the edge that toggled `sck`. The two strobes are never high together.
- R8: A change of `pre_code` or `scl_code` during a frame does not alter the half period of that frame.
- R9: An edge that samples `run` low ends the frame. In the following cycle `sck` is idle and both strobes are low.
- R10: A change of `cpol` or `cpha` during a frame does not alter that frame's clock level or strobe assignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Frame request from the frame engine |
| pre_code | input | 2 | Prescaler selection code |
| scl_code | input | 4 | Scaler selection code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: shift on leading edge |
| sck | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle pulse: launch the next bit |
| sample_stb | output | 1 | One-cycle pulse: capture the incoming bit |

## Verification
The properties assume that `run` is a synchronous level driven between clock edges. They also assume that `cpol` changes only between edges, so a combinational idle `sck` settles before it is sampled. They make no assumption about the code inputs, which may move at any time.

The stimulus drives every input on the falling edge. It holds `run` high for a whole number of half periods and then lowers it. Once a frame has started, it scrambles the codes, polarity and phase to exercise the latching rules.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int PRE_W  = 2;
  localparam int SCL_W  = 4;
  // largest half period: factor 7 times half of the top scaler value
  localparam int MAX_HALF = 7 * (2 ** ((2 ** SCL_W) - 2));
  localparam int HALF_W = $clog2(MAX_HALF + 1);

  function automatic logic [2:0] pre_factor(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  // half of the scaler value: linear for the low codes, power of two above
  function automatic logic [HALF_W-1:0] scl_half(input logic [SCL_W-1:0] code);
    if (code < SCL_W'(4)) return HALF_W'(code) + HALF_W'(1);
    else                  return HALF_W'(1) << (code - SCL_W'(1));
  endfunction
endpackage

// File: rtl/sck_ratio_decode.sv
module sck_ratio_decode
  import spi_sck_pkg::*;
(
  input  logic [PRE_W-1:0]  pre_code,
  input  logic [SCL_W-1:0]  scl_code,
  output logic [HALF_W-1:0] half_cycles
);
  logic [HALF_W+2:0] prod;

  always_comb begin
    prod        = (HALF_W+3)'(pre_factor(pre_code)) * (HALF_W+3)'(scl_half(scl_code));
    half_cycles = prod[HALF_W-1:0];
  end
endmodule

// File: rtl/sck_half_counter.sv
module sck_half_counter
  import spi_sck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              go,
  input  logic [HALF_W-1:0] half_in,
  output logic [HALF_W-1:0] half_q,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = go && (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_W'(2);
    end else if (start) begin
      cnt_q  <= '0;
      half_q <= half_in;
    end else if (go) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic go,
  input  logic active,
  input  logic tick,
  input  logic cpol_in,
  input  logic cpha_in,
  output logic sck,
  output logic shift_stb,
  output logic sample_stb
);
  logic lvl_q, cpol_q, cpha_q;

  assign sck = active ? (cpol_q ^ lvl_q) : cpol_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (start) begin
      lvl_q      <= 1'b0;
      cpol_q     <= cpol_in;
      cpha_q     <= cpha_in;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (!go) begin
      lvl_q      <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (tick) begin
      // lvl_q low means this toggle is a leading edge
      lvl_q      <= ~lvl_q;
      shift_stb  <= cpha_q ? ~lvl_q : lvl_q;
      sample_stb <= cpha_q ? lvl_q : ~lvl_q;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div
  import spi_sck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sck,
  output logic             shift_stb,
  output logic             sample_stb
);
  logic              active_q;
  logic              start, go, tick;
  logic [HALF_W-1:0] half_dec, half_q;

  assign start = run && !active_q;
  assign go    = run && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= run;
  end

  sck_ratio_decode u_dec (
    .pre_code    (pre_code),
    .scl_code    (scl_code),
    .half_cycles (half_dec)
  );

  sck_half_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .go      (go),
    .half_in (half_dec),
    .half_q  (half_q),
    .tick    (tick)
  );

  sck_edge_gen u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .go         (go),
    .active     (active_q),
    .tick       (tick),
    .cpol_in    (cpol),
    .cpha_in    (cpha),
    .sck        (sck),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );
endmodule

// File: rtl/spi_sck_div_checker.sv
module spi_sck_div_checker
  import spi_sck_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              cpol,
  input logic              sck,
  input logic              shift_stb,
  input logic              sample_stb,
  input logic              active,
  input logic [HALF_W-1:0] half_q
);
  assert_idle_sck_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sck == cpol));

  assert_start_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (sck == $past(cpol)));

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_stb, sample_stb}));

  assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> (sck != $past(sck)));

  assert_ratio_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(half_q));

  assert_quiet_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(shift_stb || sample_stb));
endmodule

bind spi_sck_div spi_sck_div_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .cpol       (cpol),
  .sck        (sck),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb),
  .active     (active_q),
  .half_q     (half_q)
);

// File: tb/spi_sck_div_tb.sv
`timescale 1ns/1ps
module spi_sck_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] pre_code = '0;
  logic [3:0] scl_code = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sck, shift_stb, sample_stb;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_sck_div u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_code(pre_code), .scl_code(scl_code),
    .cpol(cpol), .cpha(cpha), .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  function automatic int pre_val(input int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int scl_val(input int c);
    case (c)
      0: return 2;     1: return 4;     2: return 6;     3: return 8;
      4: return 16;    5: return 32;    6: return 64;    7: return 128;
      8: return 256;   9: return 512;   10: return 1024; 11: return 2048;
      12: return 4096; 13: return 8192; 14: return 16384;
      default: return 32768;
    endcase
  endfunction

  function automatic int exp_half(input int p, input int s);
    return pre_val(p) * scl_val(s) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // runs a frame of nedges toggles; scramble moves all config inputs after start
  task automatic frame(input int p, input int s, input bit pol, input bit pha,
                       input int nedges, input bit scramble, input string ttag);
    int h = exp_half(p, s);
    int total = h * nedges;
    bit lvl_e;
    bit edge_e;
    @(negedge clk);
    pre_code = 2'(p); scl_code = 4'(s); cpol = pol; cpha = pha; run = 1'b1;
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      lvl_e  = pol ^ ((j / h) % 2 == 1);
      edge_e = (j > 0) && (j % h == 0);
      check(sck == lvl_e, scramble ? "R10" : ttag, int'(sck), int'(lvl_e));
      check(!(shift_stb && sample_stb), "R7", int'({shift_stb, sample_stb}), 0);
      if (edge_e) begin
        // odd toggles are leading edges
        if (((j / h) % 2 == 1) ^ pha)
          check(sample_stb && !shift_stb, pha ? "R6" : "R5", int'({shift_stb, sample_stb}), 1);
        else
          check(shift_stb && !sample_stb, pha ? "R6" : "R5", int'({shift_stb, sample_stb}), 2);
      end else begin
        check(!shift_stb && !sample_stb, scramble ? "R8" : "R7", int'({shift_stb, sample_stb}), 0);
      end
      if (scramble && j == 0) begin
        pre_code = 2'($urandom_range(0, 3)); scl_code = 4'($urandom_range(0, 15));
        cpol = ~pol; cpha = ~pha;
      end
    end
    run = 1'b0;
    cpol = $urandom_range(0, 1);
    @(negedge clk);
    check(sck == cpol, "R9", int'(sck), int'(cpol));
    check(!shift_stb && !sample_stb, "R9", int'({shift_stb, sample_stb}), 0);
    @(negedge clk);
    check(sck == cpol, "R1", int'(sck), int'(cpol));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && !shift_stb && !sample_stb, "R1", int'({sck, shift_stb, sample_stb}), 0);
    cpol = 1'b1;
    #1;
    check(sck == 1'b1, "R1", int'(sck), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck == 1'b1, "R1", int'(sck), 1);
    // prescaler sweep
    for (int p = 0; p < 4; p++) frame(p, 0, p[0], p[1], 4, 1'b0, "R3");
    // scaler sweep over the linear and power-of-two regions
    for (int s = 0; s < 8; s++) frame(0, s, s[0], s[1], 4, 1'b0, "R4");
    // first edge timing with both phases and polarities
    frame(1, 2, 1'b1, 1'b1, 3, 1'b0, "R2");
    frame(2, 1, 1'b0, 1'b0, 3, 1'b0, "R2");
    // random frames with inputs scrambled mid-frame
    for (int k = 0; k < 30; k++)
      frame($urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(2, 6), 1'b1, "R8");
    // largest ratio: first toggle only
    frame(3, 15, 1'b0, 1'b1, 1, 1'b0, "R4");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule